// File: doc/BRIEF.md
# I/O Bridge Fault Status Capture

This block records asynchronous faults reported to an I/O bridge. Each fault event carries a type (programmed I/O, DMA read or DMA write), a set of detail fields (doubleword offset, log2 transfer size, requester ID and an optional 8-bit ECC syndrome) and the faulting address.

The first accepted fault becomes the primary error. The block stores its details and its address and sets one primary cause bit. Any fault that arrives while a primary cause is still set only sets a secondary cause bit for its type. Software reads a status word, an address word and a control word through a small register port. It clears cause bits by writing ones to them. A single interrupt output stays high while any cause bit is set and the selected interrupt enable is on.

The parameter `CORRECTABLE` picks one of two variants. The correctable-error variant keeps the syndrome field and gates the interrupt with control bit 61. The uncorrectable-error variant reads the syndrome field as zero and gates the interrupt with control bit 62.

Top module: `fault_capture_top`

## Requirements
- R1: After a synchronous active-high reset, the status, address and control registers read as zero and `irq` is low.
- R2: An accepted event with `ev_kind` = 0 (PIO), 1 (DMA read) or 2 (DMA write) sets status bit 63, 62 or 61 respectively, provided that none of bits 63:61 was set before the clock edge. At most one of bits 63:61 is set at any time.
- R3: On a primary capture, status bits 47:45 take `ev_dw_off`, bits 44:42 take `ev_log_size`, bits 41:37 take `ev_req_id` and bits 55:48 take `ev_syndrome` (the syndrome field reads zero when `CORRECTABLE` = 0). The address register takes `ev_addr`, zero-extended to 64 bits.
- R4: An accepted event that arrives while one of bits 63:61 is set sets only the secondary bit for its type: bit 60 for PIO, bit 59 for DMA read, bit 58 for DMA write. The detail fields and the address register stay unchanged.
- R5: A write to the status register (`reg_sel` = 0) clears every cause bit in 63:58 whose write-data bit is 1 and leaves the bits written 0 unchanged. When a write and an event fall on the same edge, the state before the edge decides between primary and secondary, and the bit set by the event survives the clear.
- R6: Control bit 63 enables checking. While it is 0, events change no register.
- R7: `irq` is high exactly when any status bit 63:58 is set and the interrupt enable (control bit 61 when `CORRECTABLE` = 1, bit 62 otherwise) is 1. It updates on the same edge as the state it depends on.
- R8: Only control bits 63:61 can be written, and all other control bits read zero. Writes to the status detail bits, to the status reserved bits and to the address register have no effect.
- R9: `reg_sel` selects 0 = status, 1 = address, 2 = control, 3 = reads zero. `reg_rdata` is registered and shows the selected register as it stood before the edge that loaded it.
- R10: An event with `ev_kind` = 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Fault event strobe, one cycle per event |
| ev_kind | input | 2 | Fault type: 0 PIO, 1 DMA read, 2 DMA write, 3 reserved |
| ev_dw_off | input | 3 | Doubleword offset of the fault |
| ev_log_size | input | 3 | log2 of the transfer size |
| ev_req_id | input | 5 | Requester module ID |
| ev_syndrome | input | 8 | ECC syndrome |
| ev_addr | input | ADDR_W | Faulting address |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| irq | output | 1 | Fault interrupt |

## Verification
Directed sequences test the primary-then-secondary ordering with differing detail values. A difference in the read-back detail fields shows whether a later event overwrote them. Same-edge combinations of write-one-to-clear and events separate a design that decides primary status from the old state from one that uses the post-clear state. Random traffic mixes all four event kinds, enable settings and random clear masks. It runs against a bench model, which exposes errors in the enable gating, in the reserved-bit masking and in the interrupt timing.

// File: rtl/fault_capture_pkg.sv
package fault_capture_pkg;

  typedef enum logic [1:0] {
    KIND_PIO  = 2'd0,
    KIND_DRD  = 2'd1,
    KIND_DWR  = 2'd2,
    KIND_RSVD = 2'd3
  } fault_kind_e;

  typedef struct packed {
    logic [7:0] syndrome;
    logic [2:0] dw_off;
    logic [2:0] log_size;
    logic [4:0] req_id;
  } fault_detail_t;

  localparam int unsigned REG_W     = 64;
  localparam int unsigned CAUSE_W   = 6;
  localparam int unsigned CTRL_W    = 3;
  localparam int unsigned LOW_PAD_W = 37;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_ADDR   = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;

endpackage

// File: rtl/fault_ctrl_reg.sv
module fault_ctrl_reg
  import fault_capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_bits,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] ctrl_next
);

  always_comb begin
    ctrl_next = wr_en ? wr_bits : ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_next;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl_q)); // R8

endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fault_capture_pkg::*;
#(
  parameter bit HAS_SYND = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chk_en,
  input  logic               ev_valid,
  input  logic [1:0]         ev_kind,
  input  fault_detail_t      ev_detail,
  input  logic               clr_we,
  input  logic [CAUSE_W-1:0] clr_mask,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [CAUSE_W-1:0] cause_next,
  output fault_detail_t      detail_q,
  output logic               capture
);

  localparam int unsigned HALF = CAUSE_W / 2;

  logic [HALF-1:0] kind_bit;
  logic            accept;
  logic            prim_busy;
  logic [7:0]      synd_src;
  fault_detail_t   detail_in;

  always_comb begin
    case (fault_kind_e'(ev_kind))
      KIND_PIO: kind_bit = 3'b100;
      KIND_DRD: kind_bit = 3'b010;
      KIND_DWR: kind_bit = 3'b001;
      default:  kind_bit = 3'b000;
    endcase
  end

  generate
    if (HAS_SYND) begin : g_synd
      assign synd_src = ev_detail.syndrome;
    end else begin : g_nosynd
      assign synd_src = 8'h00;
    end
  endgenerate

  assign accept    = ev_valid && chk_en && (kind_bit != '0);
  assign prim_busy = |cause_q[CAUSE_W-1:HALF];
  assign capture   = accept && !prim_busy;

  always_comb begin
    detail_in          = ev_detail;
    detail_in.syndrome = synd_src;
    cause_next = cause_q & ~(clr_we ? clr_mask : '0);
    if (capture)     cause_next[CAUSE_W-1:HALF] = cause_next[CAUSE_W-1:HALF] | kind_bit;
    else if (accept) cause_next[HALF-1:0]       = cause_next[HALF-1:0] | kind_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q  <= '0;
      detail_q <= '0;
    end else begin
      cause_q <= cause_next;
      if (capture) detail_q <= detail_in;
    end
  end

  AST_PRIM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cause_q[CAUSE_W-1:HALF])); // R2
  AST_DETAIL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (prim_busy && !clr_we) |=> $stable(detail_q)); // R4
  AST_CHECK_OFF: assert property (@(posedge clk) disable iff (rst)
    (!chk_en && !clr_we) |=> $stable(cause_q)); // R6
  AST_W1C_PIO: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_mask[CAUSE_W-1] && !(capture && kind_bit[HALF-1])) |=> !cause_q[CAUSE_W-1]); // R5

endmodule

// File: rtl/fault_addr_reg.sv
module fault_addr_reg #(
  parameter int unsigned ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (capture) addr_q <= ev_addr;
  end

  AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(addr_q)); // R4

endmodule

// File: rtl/fault_capture_top.sv
module fault_capture_top
  import fault_capture_pkg::*;
#(
  parameter int unsigned ADDR_W      = 40,
  parameter bit          CORRECTABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [2:0]        ev_dw_off,
  input  logic [2:0]        ev_log_size,
  input  logic [4:0]        ev_req_id,
  input  logic [7:0]        ev_syndrome,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              irq
);

  localparam int unsigned ADDR_PAD = REG_W - ADDR_W;
  localparam int unsigned CTRL_PAD = REG_W - CTRL_W;

  logic [CTRL_W-1:0]  ctrl_q, ctrl_next;
  logic [CAUSE_W-1:0] cause_q, cause_next;
  fault_detail_t      detail_q, ev_detail;
  logic               capture;
  logic [ADDR_W-1:0]  addr_q;
  logic               ie_q, ie_next;
  logic [63:0]        status_word, rd_mux;

  assign ev_detail = '{syndrome: ev_syndrome, dw_off: ev_dw_off,
                       log_size: ev_log_size, req_id: ev_req_id};

  fault_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_we && reg_sel == SEL_CTRL),
    .wr_bits   (reg_wdata[REG_W-1 -: CTRL_W]),
    .ctrl_q    (ctrl_q),
    .ctrl_next (ctrl_next)
  );

  fault_status_reg #(.HAS_SYND(CORRECTABLE)) u_status (
    .clk        (clk),
    .rst        (rst),
    .chk_en     (ctrl_q[2]),
    .ev_valid   (ev_valid),
    .ev_kind    (ev_kind),
    .ev_detail  (ev_detail),
    .clr_we     (reg_we && reg_sel == SEL_STATUS),
    .clr_mask   (reg_wdata[REG_W-1 -: CAUSE_W]),
    .cause_q    (cause_q),
    .cause_next (cause_next),
    .detail_q   (detail_q),
    .capture    (capture)
  );

  fault_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .ev_addr (ev_addr),
    .addr_q  (addr_q)
  );

  generate
    if (CORRECTABLE) begin : g_ie_ce
      assign ie_q    = ctrl_q[0];
      assign ie_next = ctrl_next[0];
    end else begin : g_ie_ue
      assign ie_q    = ctrl_q[1];
      assign ie_next = ctrl_next[1];
    end
  endgenerate

  assign status_word = {cause_q, 2'b00, detail_q.syndrome, detail_q.dw_off,
                        detail_q.log_size, detail_q.req_id, {LOW_PAD_W{1'b0}}};

  always_comb begin
    case (reg_sel)
      SEL_STATUS: rd_mux = status_word;
      SEL_ADDR:   rd_mux = {{ADDR_PAD{1'b0}}, addr_q};
      SEL_CTRL:   rd_mux = {ctrl_q, {CTRL_PAD{1'b0}}};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq       <= ie_next && (|cause_next);
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ie_q && (|cause_q))); // R7
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    (ie_q && (|cause_q)) |-> irq); // R7
  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_sel) == SEL_CTRL) |-> (reg_rdata[CTRL_PAD-1:0] == '0)); // R8

endmodule

// File: tb/fault_capture_top_tb.sv
module fault_capture_top_tb;

  localparam int unsigned ADDR_W = 40;

  logic              clk = 1'b0;
  logic              rst;
  logic              ev_valid;
  logic [1:0]        ev_kind;
  logic [2:0]        ev_dw_off, ev_log_size;
  logic [4:0]        ev_req_id;
  logic [7:0]        ev_syndrome;
  logic [ADDR_W-1:0] ev_addr;
  logic [1:0]        reg_sel;
  logic              reg_we;
  logic [63:0]       reg_wdata;
  logic [63:0]       reg_rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;

  logic [5:0]        m_cause;
  logic [2:0]        m_doff, m_size, m_ctrl;
  logic [4:0]        m_mid;
  logic [7:0]        m_synd;
  logic [ADDR_W-1:0] m_addr;

  always #5 clk = ~clk;

  fault_capture_top #(.ADDR_W(ADDR_W), .CORRECTABLE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_dw_off(ev_dw_off), .ev_log_size(ev_log_size), .ev_req_id(ev_req_id),
    .ev_syndrome(ev_syndrome), .ev_addr(ev_addr), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [63:0] exp_status();
    return {m_cause, 2'b00, m_synd, m_doff, m_size, m_mid, 37'b0};
  endfunction

  function automatic logic [2:0] kind_onehot(input logic [1:0] k);
    case (k)
      2'd0:    return 3'b100;
      2'd1:    return 3'b010;
      2'd2:    return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_valid = 1'b0; reg_we = 1'b0; reg_wdata = '0;
  endtask

  // one clock with the current inputs; updates the model from the old state
  task automatic apply(input string tag);
    logic [2:0] t;
    logic [5:0] c;
    logic [2:0] cn;
    cn = (reg_we && reg_sel == 2'd2) ? reg_wdata[63:61] : m_ctrl;
    c  = m_cause & ~((reg_we && reg_sel == 2'd0) ? reg_wdata[63:58] : 6'b0);
    t  = kind_onehot(ev_kind);
    if (ev_valid && m_ctrl[2] && t != 3'b000) begin
      if (|m_cause[5:3]) c[2:0] = c[2:0] | t;
      else begin
        c[5:3] = c[5:3] | t;
        m_doff = ev_dw_off; m_size = ev_log_size; m_mid = ev_req_id;
        m_synd = ev_syndrome; m_addr = ev_addr;
      end
    end
    m_cause = c; m_ctrl = cn;
    @(posedge clk); #1;
    idle_inputs();
    check({tag, " irq"}, {63'b0, irq}, {63'b0, (m_ctrl[0] && (|m_cause))});
  endtask

  task automatic read_all(input string tag);
    reg_sel = 2'd0; @(posedge clk); #1;
    check({tag, " status"}, reg_rdata, exp_status());
    reg_sel = 2'd1; @(posedge clk); #1;
    check({tag, " addr"}, reg_rdata, {24'b0, m_addr});
    reg_sel = 2'd2; @(posedge clk); #1;
    check({tag, " ctrl"}, reg_rdata, {m_ctrl, 61'b0});
  endtask

  task automatic set_event(input logic [1:0] k, input logic [2:0] d, input logic [2:0] s,
                           input logic [4:0] id, input logic [7:0] sy, input logic [ADDR_W-1:0] a);
    ev_valid = 1'b1; ev_kind = k; ev_dw_off = d; ev_log_size = s;
    ev_req_id = id; ev_syndrome = sy; ev_addr = a;
  endtask

  task automatic set_write(input logic [1:0] sel, input logic [63:0] data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C41));
    idle_inputs();
    ev_kind = 0; ev_dw_off = 0; ev_log_size = 0; ev_req_id = 0; ev_syndrome = 0; ev_addr = '0;
    reg_sel = 0;
    m_cause = 0; m_doff = 0; m_size = 0; m_mid = 0; m_synd = 0; m_addr = '0; m_ctrl = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1 irq", {63'b0, irq}, 64'b0);
    read_all("R1");
    reg_sel = 2'd3; @(posedge clk); #1;
    check("R9 sel3", reg_rdata, 64'b0);

    // R8: only 63:61 of control stick; address and detail writes ignored
    set_write(2'd2, '1); apply("R8");
    set_write(2'd1, '1); apply("R8");
    set_write(2'd0, 64'h03FF_FFFF_FFFF_FFFF); apply("R8");
    read_all("R8");

    // R2 R3: first PIO event becomes primary with details
    set_event(2'd0, 3'd5, 3'd3, 5'd17, 8'hA5, 40'h12_3456_789A); apply("R2");
    read_all("R3");
    // R4: later DMA write goes to secondary, details kept
    set_event(2'd2, 3'd1, 3'd6, 5'd2, 8'h3C, 40'hFF_0000_1111); apply("R4");
    read_all("R4");
    // R5: zero write leaves, then clear secondaries only
    set_write(2'd0, 64'h0); apply("R5");
    set_write(2'd0, 64'h0400_0000_0000_0000); apply("R5");
    read_all("R5");
    // R5: clear primary with a DMA read event on the same edge -> secondary
    set_write(2'd0, 64'h8000_0000_0000_0000);
    set_event(2'd1, 3'd7, 3'd7, 5'd31, 8'hFF, 40'h00_DEAD_BEEF); apply("R5");
    read_all("R5 same edge");
    // R5: now no primary; next event captures as primary
    set_write(2'd0, 64'hFC00_0000_0000_0000); apply("R5");
    set_event(2'd2, 3'd2, 3'd4, 5'd9, 8'h11, 40'h55_AAAA_0000); apply("R2");
    read_all("R2 dwr");
    // R10: reserved kind ignored
    set_write(2'd0, 64'hFC00_0000_0000_0000); apply("R10");
    set_event(2'd3, 3'd6, 3'd6, 5'd6, 8'h66, 40'h66_6666_6666); apply("R10");
    read_all("R10");
    // R6: checking off ignores events
    set_write(2'd2, 64'h2000_0000_0000_0000); apply("R6");
    set_event(2'd0, 3'd3, 3'd3, 5'd3, 8'h33, 40'h33_3333_3333); apply("R6");
    read_all("R6");
    // R7: enable off, event captured, irq low; enabling raises it
    set_write(2'd2, 64'h8000_0000_0000_0000); apply("R7");
    set_event(2'd1, 3'd4, 3'd2, 5'd8, 8'h80, 40'h01_0203_0405); apply("R7");
    set_write(2'd2, 64'hA000_0000_0000_0000); apply("R7");
    read_all("R7");

    for (int i = 0; i < 400; i++) begin
      if ($urandom % 2 == 0)
        set_event(2'($urandom), 3'($urandom), 3'($urandom), 5'($urandom), 8'($urandom),
                  {8'($urandom), 32'($urandom)});
      if ($urandom % 10 < 3) begin
        set_write(2'($urandom), {32'($urandom), 32'($urandom)});
        if (reg_sel == 2'd2) reg_wdata[63] = ($urandom % 5 != 0);
      end
      apply("R2 random");
      if (i % 4 == 0) read_all("R4 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule